// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous Static Memory

This block is a single-port synchronous static memory whose command, address and data paths are all registered. A new read or write command may be issued on every enabled clock edge, and reads and writes can follow each other with no idle cycle between them. The write data for a command is sampled from the data input two enabled edges after the command. Read data leaves the output register two enabled edges after the read command. Each word is split into nine-bit lanes, and each lane has its own active-low write mask.

A load/advance control either loads a fresh address or steps a two-bit burst counter. The low two address bits seed this counter, and it wraps inside an aligned group of four words. Three chip-enable inputs (two active-low, one active-high) qualify every load. A load with a false enable deselects the block. A global active-low clock enable freezes the whole pipeline, including the output register.

The burst controller has three states. ST_IDLE means no burst is open, ST_RD means a read burst is open and ST_WR means a write burst is open. It moves between them on four transitions:
- load-read: a selected load with the write enable high enters ST_RD.
- load-write: a selected load with the write enable low enters ST_WR.
- deselect: a load with any chip enable false enters ST_IDLE.
- advance: the load/advance control is high, so the state holds and, in ST_RD or ST_WR, the counter steps.

Top module: `zt_sram`

## Requirements
- R1: While reset is asserted and right after it, `dout_oe` is 0 and `dout` is all zeros.
- R2: A read command sampled on enabled edge k puts the stored word on `dout` with `dout_oe`=1 after enabled edge k+2. `dout_oe` is 0 in every data slot that carries no read data.
- R3: A write command takes its data from `din` at the second enabled edge after the command and its masks from `bw_n` at the command edge. Lane i is bits [9i+8:9i], and the lane is written only when `bw_n[i]`=0.
- R4: The block is selected when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0. A selected load (`adv_ld`=0) issues a read when `we_n`=1 and a write when `we_n`=0, and seeds the burst counter from `addr[1:0]`.
- R5: With `adv_ld`=1 after a selected load, each enabled edge issues the same kind of command at address {upper bits of the load, counter+1 mod 4}. `we_n` is ignored on advance cycles.
- R6: A load with any chip enable false issues no access and closes the burst. Advance cycles that follow it also issue no access, and their data slots have `dout_oe`=0.
- R7: When `cen_n`=1 at an edge, nothing changes: no write, no command and no counter step, and `dout` and `dout_oe` hold.
- R8: A read issued on the edge right after a write to the same address returns the new lanes of that write merged with the old lanes it masked off.
- R9: Every write beat, including advance beats, uses its own `bw_n`. `bw_n` has no effect on read commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cen_n | input | 1 | Active-low clock enable; high freezes the block |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | Active-low write select on load cycles |
| ce_a_n | input | 1 | Active-low chip enable |
| ce_b | input | 1 | Active-high chip enable |
| ce_c_n | input | 1 | Active-low chip enable |
| addr | input | AW | Word address |
| bw_n | input | LANES | Active-low per-lane write masks |
| din | input | LANES*LANE_W | Write data, sampled two enabled edges after its command |
| dout | output | LANES*LANE_W | Registered read data |
| dout_oe | output | 1 | Output-driver enable, high only for read-data slots |

## Verification
The bench runs a small 16-word configuration. Burst writes and reads start at every offset inside a group, which separates linear wrap from plain incrementing and shows that `we_n` is ignored on advances. All sixteen mask values are applied to a load beat and to its advance beat. Back-to-back write-then-read pairs, with and without a gap, check the forwarding of a pending write against the plain array read. Every false chip-enable combination and a long mixed stream with random clock-enable stalls show whether a deselect or a stalled edge leaks into memory, the counter or the output register.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } zt_burst_e;
endpackage

// File: rtl/zt_cmd_fsm.sv
`timescale 1ns/1ps
module zt_cmd_fsm
    import zt_sram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic              sel,
    input  logic [AW-1:0]     addr,
    input  logic [LANES-1:0]  bw_n,
    output zt_burst_e         state,
    output logic [BURST_W-1:0] burst_cnt,
    output logic              iss_v,
    output logic              iss_wr,
    output logic [AW-1:0]     iss_addr,
    output logic [LANES-1:0]  iss_bw_n
);
    localparam int HI_W = AW - BURST_W;

    zt_burst_e          state_d;
    logic [HI_W-1:0]    hi_q, hi_d;
    logic [BURST_W-1:0] cnt_d;

    // next-state logic: load-read, load-write, deselect, advance
    always_comb begin
        state_d = state;
        hi_d    = hi_q;
        cnt_d   = burst_cnt;
        if (!adv_ld) begin
            if (sel) begin
                state_d = we_n ? ST_RD : ST_WR;
                hi_d    = addr[AW-1:BURST_W];
                cnt_d   = addr[BURST_W-1:0];
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state)
                ST_IDLE:      cnt_d = burst_cnt;
                ST_RD, ST_WR: cnt_d = burst_cnt + BURST_W'(1);
                default:      cnt_d = burst_cnt;
            endcase
        end
    end

    // command issued on this edge
    always_comb begin
        iss_v    = 1'b0;
        iss_wr   = 1'b0;
        iss_addr = addr;
        iss_bw_n = bw_n;
        if (!adv_ld) begin
            if (sel) begin
                iss_v  = 1'b1;
                iss_wr = !we_n;
            end
        end else begin
            unique case (state)
                ST_IDLE: iss_v = 1'b0;
                ST_RD: begin
                    iss_v    = 1'b1;
                    iss_addr = {hi_q, cnt_d};
                end
                ST_WR: begin
                    iss_v    = 1'b1;
                    iss_wr   = 1'b1;
                    iss_addr = {hi_q, cnt_d};
                end
                default: iss_v = 1'b0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hi_q      <= '0;
            burst_cnt <= '0;
        end else if (en) begin
            state     <= state_d;
            hi_q      <= hi_d;
            burst_cnt <= cnt_d;
        end
    end
endmodule

// File: rtl/zt_pipe.sv
`timescale 1ns/1ps
module zt_pipe #(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             iss_v,
    input  logic             iss_wr,
    input  logic [AW-1:0]    iss_addr,
    input  logic [LANES-1:0] iss_bw_n,
    output logic [AW-1:0]    s1_addr,
    output logic             s2_v,
    output logic             s2_wr,
    output logic [AW-1:0]    s2_addr,
    output logic [LANES-1:0] s2_bw_n
);
    logic             s1_v, s1_wr;
    logic [LANES-1:0] s1_bw_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_wr   <= 1'b0;
            s1_addr <= '0;
            s1_bw_n <= '1;
            s2_v    <= 1'b0;
            s2_wr   <= 1'b0;
            s2_addr <= '0;
            s2_bw_n <= '1;
        end else if (en) begin
            s1_v    <= iss_v;
            s1_wr   <= iss_wr;
            s1_addr <= iss_addr;
            s1_bw_n <= iss_bw_n;
            s2_v    <= s1_v;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_bw_n <= s1_bw_n;
        end
    end
endmodule

// File: rtl/zt_store.sv
`timescale 1ns/1ps
module zt_store #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [AW-1:0]    s1_addr,
    input  logic             s2_v,
    input  logic             s2_wr,
    input  logic [AW-1:0]    s2_addr,
    input  logic [LANES-1:0] s2_bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] rd_buf
);
    localparam int DW    = LANES * LANE_W;
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]    mem [DEPTH];
    logic [DW-1:0]    rd_word, merged;
    logic             wr_go, fwd_en;
    logic [LANES-1:0] hit;

    assign wr_go   = en && s2_v && s2_wr;
    assign fwd_en  = s2_v && s2_wr && (s2_addr == s1_addr);
    assign rd_word = mem[s1_addr];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = i * LANE_W;
        assign hit[i] = fwd_en && !s2_bw_n[i];
        assign merged[LO +: LANE_W] = hit[i] ? din[LO +: LANE_W] : rd_word[LO +: LANE_W];
    end

    always_ff @(posedge clk) begin
        if (wr_go) begin
            for (int i = 0; i < LANES; i++) begin
                if (!s2_bw_n[i]) mem[s2_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_buf <= '0;
        else if (en) rd_buf <= merged;
    end
endmodule

// File: rtl/zt_out.sv
`timescale 1ns/1ps
module zt_out #(
    parameter int DW = 36
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          s2_v,
    input  logic          s2_wr,
    input  logic [DW-1:0] rd_buf,
    output logic [DW-1:0] dout,
    output logic          dout_oe
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_oe <= 1'b0;
        end else if (en) begin
            dout_oe <= s2_v && !s2_wr;
            if (s2_v && !s2_wr) dout <= rd_buf;
        end
    end
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cen_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic                    ce_a_n,
    input  logic                    ce_b,
    input  logic                    ce_c_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_oe
);
    localparam int DW = LANES * LANE_W;

    logic               en, sel;
    zt_burst_e          state;
    logic [BURST_W-1:0] burst_cnt;
    logic               iss_v, iss_wr;
    logic [AW-1:0]      iss_addr, s1_addr, s2_addr;
    logic [LANES-1:0]   iss_bw_n, s2_bw_n;
    logic               s2_v, s2_wr;
    logic [DW-1:0]      rd_buf;

    assign en  = !cen_n;
    assign sel = !ce_a_n && ce_b && !ce_c_n;

    zt_cmd_fsm #(.AW(AW), .LANES(LANES)) i_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .adv_ld(adv_ld), .we_n(we_n), .sel(sel),
        .addr(addr), .bw_n(bw_n), .state(state), .burst_cnt(burst_cnt),
        .iss_v(iss_v), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_bw_n(iss_bw_n)
    );

    zt_pipe #(.AW(AW), .LANES(LANES)) i_pipe (
        .clk(clk), .rst_n(rst_n), .en(en), .iss_v(iss_v), .iss_wr(iss_wr),
        .iss_addr(iss_addr), .iss_bw_n(iss_bw_n), .s1_addr(s1_addr),
        .s2_v(s2_v), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n)
    );

    zt_store #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) i_store (
        .clk(clk), .rst_n(rst_n), .en(en), .s1_addr(s1_addr), .s2_v(s2_v),
        .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_bw_n(s2_bw_n), .din(din), .rd_buf(rd_buf)
    );

    zt_out #(.DW(DW)) i_out (
        .clk(clk), .rst_n(rst_n), .en(en), .s2_v(s2_v), .s2_wr(s2_wr),
        .rd_buf(rd_buf), .dout(dout), .dout_oe(dout_oe)
    );
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk
    import zt_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cen_n,
    input logic               adv_ld,
    input logic               ce_a_n,
    input logic               ce_b,
    input logic               ce_c_n,
    input logic [AW-1:0]      addr,
    input logic [DW-1:0]      dout,
    input logic               dout_oe,
    input zt_burst_e          state,
    input logic [BURST_W-1:0] burst_cnt,
    input logic               s2_v,
    input logic               s2_wr
);
    logic on, picked;
    assign on     = !cen_n;
    assign picked = !ce_a_n && ce_b && !ce_c_n;

    always_comb begin
        if (rst_n == 1'b0) begin
            p_quiet_in_reset_r1: assert (!dout_oe && dout == '0);
        end
    end

    p_oe_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        on && s2_v && !s2_wr |=> dout_oe);

    p_oe_low_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on && !(s2_v && !s2_wr) |=> !dout_oe);

    p_seed_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        on && !adv_ld && picked |=> burst_cnt == $past(addr[BURST_W-1:0]));

    p_linear_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        on && adv_ld && state != ST_IDLE |=> burst_cnt == $past(burst_cnt) + BURST_W'(1));

    p_deselect_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        on && !adv_ld && !picked |=> state == ST_IDLE);

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !on |=> $stable(dout) && $stable(dout_oe) && $stable(state) && $stable(burst_cnt));
endmodule

bind zt_sram zt_sram_chk #(.AW(AW), .DW(LANES*LANE_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld), .ce_a_n(ce_a_n),
    .ce_b(ce_b), .ce_c_n(ce_c_n), .addr(addr), .dout(dout), .dout_oe(dout_oe),
    .state(state), .burst_cnt(burst_cnt), .s2_v(s2_v), .s2_wr(s2_wr)
);

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
    localparam int AW = 4;
    localparam int LN = 4;
    localparam int LW = 9;
    localparam int DW = LN * LW;
    localparam int WORDS = 1 << AW;
    localparam logic [2:0] SEL = 3'b010;   // {ce_c_n, ce_b, ce_a_n}

    logic clk = 1'b0, rst_n = 1'b0;
    logic cen_n = 1'b1, adv_ld = 1'b0, we_n = 1'b1;
    logic ce_a_n = 1'b1, ce_b = 1'b0, ce_c_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] bw_n = '1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_oe;

    always #10 clk = ~clk;

    zt_sram #(.AW(AW), .LANES(LN), .LANE_W(LW)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .adv_ld(adv_ld), .we_n(we_n),
        .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n), .addr(addr), .bw_n(bw_n),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    int checks = 0, bad = 0;
    bit finished = 1'b0;
    string cur_req = "R1";
    logic [31:0] rng = 32'h1234_5678;

    // bench reference model
    logic [DW-1:0] sm [WORDS];
    logic          m_v [2], m_wr [2];
    logic [AW-1:0] m_a [2];
    logic [LN-1:0] m_bw [2];
    logic [DW-1:0] m_d [2];
    int            mst = 0;               // 0 idle, 1 read burst, 2 write burst
    logic [AW-3:0] mhi = '0;
    logic [1:0]    mcnt = '0;
    logic          exp_oe = 1'b0;
    logic [DW-1:0] exp_dout = '0;

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    function automatic logic [DW-1:0] junk();
        rng = nxt(rng);
        return {rng[3:0], rng};
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int seed);
        logic [DW-1:0] w;
        for (int i = 0; i < LN; i++) w[i*LW +: LW] = LW'(a * 29 + i * 83 + seed * 17 + 3);
        return w;
    endfunction

    task automatic model_edge(input logic adv, input logic we, input logic [2:0] ce,
                              input logic [AW-1:0] a, input logic [LN-1:0] bw,
                              input logic [DW-1:0] d);
        if (m_v[1] && m_wr[1]) begin
            for (int i = 0; i < LN; i++)
                if (!m_bw[1][i]) sm[m_a[1]][i*LW +: LW] = m_d[1][i*LW +: LW];
        end
        if (m_v[1] && !m_wr[1]) exp_dout = sm[m_a[1]];
        exp_oe = m_v[1] && !m_wr[1];
        m_v[1] = m_v[0]; m_wr[1] = m_wr[0]; m_a[1] = m_a[0]; m_bw[1] = m_bw[0]; m_d[1] = m_d[0];
        m_bw[0] = bw; m_d[0] = d;
        if (!adv) begin
            if (ce == SEL) begin
                mst = we ? 1 : 2; mhi = a[AW-1:2]; mcnt = a[1:0];
                m_v[0] = 1'b1; m_wr[0] = !we; m_a[0] = a;
            end else begin
                mst = 0; m_v[0] = 1'b0; m_wr[0] = 1'b0;
            end
        end else if (mst != 0) begin
            mcnt = mcnt + 2'd1;
            m_v[0] = 1'b1; m_wr[0] = (mst == 2); m_a[0] = {mhi, mcnt};
        end else begin
            m_v[0] = 1'b0; m_wr[0] = 1'b0;
        end
    endtask

    task automatic step(input logic c_n, input logic adv, input logic we, input logic [2:0] ce,
                        input logic [AW-1:0] a, input logic [LN-1:0] bw, input logic [DW-1:0] d);
        @(negedge clk);
        cen_n = c_n; adv_ld = adv; we_n = we; {ce_c_n, ce_b, ce_a_n} = ce; addr = a; bw_n = bw;
        din = (!c_n && m_v[1] && m_wr[1]) ? m_d[1] : junk();
        @(posedge clk);
        if (!c_n) model_edge(adv, we, ce, a, bw, d);
        #5;
        checks++;
        if (dout_oe !== exp_oe) begin
            bad++;
            $display("FAIL %s dout_oe actual=%b expected=%b", cur_req, dout_oe, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (dout !== exp_dout) begin
                bad++;
                $display("FAIL %s dout actual=%h expected=%h", cur_req, dout, exp_dout);
            end
        end
    endtask

    task automatic ld(input logic we, input logic [AW-1:0] a, input logic [LN-1:0] bw, input logic [DW-1:0] d);
        step(1'b0, 1'b0, we, SEL, a, bw, d);
    endtask
    task automatic beat(input logic we, input logic [LN-1:0] bw, input logic [DW-1:0] d);
        step(1'b0, 1'b1, we, SEL, AW'(junk()), bw, d);
    endtask
    task automatic desel();
        step(1'b0, 1'b0, 1'b0, 3'b000, AW'(junk()), '0, junk());
    endtask

    initial begin
        for (int s = 0; s < 2; s++) begin
            m_v[s] = 1'b0; m_wr[s] = 1'b0; m_a[s] = '0; m_bw[s] = '1; m_d[s] = '0;
        end
        #35;
        // R1: reset state, during and right after reset
        checks++;
        if (dout_oe !== 1'b0 || dout !== '0) begin
            bad++; $display("FAIL R1 in reset actual=%b/%h expected=0/0", dout_oe, dout);
        end
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (dout_oe !== 1'b0 || dout !== '0) begin
            bad++; $display("FAIL R1 after reset actual=%b/%h expected=0/0", dout_oe, dout);
        end

        // R4 R5 R3: write bursts from every start offset, we_n high on advances
        cur_req = "R5";
        for (int g = 0; g < WORDS / 4; g++) begin
            ld(1'b0, AW'(g * 4 + g % 4), '0, pat(g * 4 + g % 4, 1));
            for (int j = 1; j < 4; j++) beat(1'b1, '0, pat(g * 4 + (g + j) % 4, 1));
        end
        // R2 R4: read bursts with another offset, we_n low on advances (ignored)
        cur_req = "R4";
        for (int g = 0; g < WORDS / 4; g++) begin
            ld(1'b1, AW'(g * 4 + (g + 2) % 4), 4'(junk()), junk());
            for (int j = 1; j < 4; j++) beat(1'b0, 4'(junk()), junk());
        end
        cur_req = "R2";
        desel(); desel();

        // R9 R3: every mask value on a load beat and its advance beat
        cur_req = "R9";
        for (int m = 0; m < 16; m++) begin
            ld(1'b0, AW'(4), 4'(m), pat(4, m + 5));
            beat(1'b0, ~4'(m), pat(5, m + 9));
            ld(1'b1, AW'(4), 4'(junk()), junk());
            beat(1'b1, 4'(junk()), junk());
            desel(); desel();
        end

        // R8: write then read of the same word, back to back or one gap apart
        cur_req = "R8";
        for (int a = 0; a < WORDS; a++) begin
            ld(1'b0, AW'(a), 4'(a) ^ 4'h5, pat(a, 40 + a));
            if (a % 2 == 1) desel();
            ld(1'b1, AW'(a), 4'(junk()), junk());
        end
        ld(1'b0, AW'(7), 4'hC, pat(7, 90));
        ld(1'b0, AW'(7), 4'h3, pat(7, 91));
        ld(1'b1, AW'(7), '0, junk());
        desel(); desel(); desel();

        // R6: every false enable combination, with advances that try to write
        cur_req = "R6";
        for (int ce = 0; ce < 8; ce++) begin
            if (3'(ce) == SEL) continue;
            step(1'b0, 1'b0, 1'b0, 3'(ce), AW'(9), '0, junk());
            step(1'b0, 1'b1, 1'b0, 3'(ce), AW'(9), '0, junk());
            step(1'b0, 1'b1, 1'b0, 3'(ce), AW'(9), '0, junk());
            ld(1'b1, AW'(9), '0, junk());
            for (int j = 1; j < 4; j++) beat(1'b1, '0, junk());
            desel(); desel();
        end

        // R7: mixed stream with clock-enable stalls
        cur_req = "R7";
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            logic [2:0] cev;
            rng = nxt(rng); r = rng;
            cev = (r[15:14] == 2'b00) ? 3'b000 : SEL;
            step(r[0] & r[1], r[2] & r[3], r[4], cev, AW'(r[9:6]), r[13:10], pat(int'(r[9:6]), n));
        end
        desel(); desel();
        for (int a = 0; a < WORDS; a++) ld(1'b1, AW'(a), '0, junk());
        desel(); desel(); desel();

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule